// File: doc/BRIEF.md
# Priority-Road Traffic Light Controller

This block sequences the lights at a crossing of a main road and a side road, where the main road has priority. The main road shows green for a minimum number of timebase ticks set by a 4-bit input. Once that minimum has passed, it keeps green until a car is seen on the side road. The main road then shows yellow for a fixed interval and turns red. The side road shows green for its own 4-bit programmable interval, then yellow for a fixed interval whether or not more cars are waiting. It then turns red and the main road returns to green.

Time is measured in ticks of a one-cycle timebase pulse supplied by a divider outside this block. One interval counter is shared by all four phases. It restarts at each phase change, and its value is brought out so that a display block can show it. The car sensor arrives asynchronously and passes through a synchronizer chain before the sequencer uses it. Each light is a 3-bit one-hot vector.

Top module: `crossing_signal_ctrl`

## Requirements
- R1: While `rst_n` is low, and at once when it falls (asynchronous), `main_light` is 3'b100, `side_light` is 3'b001 and `elapsed` is 0.
- R2: Each light vector has exactly one bit set. Bit 2 is green, bit 1 is yellow and bit 0 is red.
- R3: In every cycle at least one of the two roads shows red.
- R4: The main green lasts at least L ticks, where L is `main_green_len`. The phase can only end on a clock edge at which `elapsed` is at least L.
- R5: After the minimum has passed, the main green ends on the first clock edge at which the synchronized sensor reads 1. While the synchronized sensor reads 0, the main green holds with no time limit.
- R6: The main yellow lasts MAIN_WARN_TICKS ticks (default 3). On the edge that ends it, the main light turns red and the side light turns green.
- R7: The side green lasts `side_green_len` ticks. It then turns yellow whatever the sensor shows.
- R8: The side yellow lasts SIDE_WARN_TICKS ticks (default 2). On the edge that ends it, the side light turns red and the main light turns green.
- R9: Every phase ends on the first clock edge at which `elapsed` is at least that phase's limit. `elapsed` is 0 after any edge that changes the phase. Otherwise it rises by 1 on each edge where `tick` is 1, and it stops rising once it reaches the current limit.
- R10: A change on `car_sense_async` reaches the sequencer through SYNC_STAGES flops (default 2). With the main green past its minimum, a car raised just after one edge turns the main light yellow on the third rising edge after that.
- R11: A value of 0 on `main_green_len` or `side_green_len` is used as a limit of 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| tick | input | 1 | One-cycle timebase pulse; the interval counter advances only on it |
| main_green_len | input | LEN_W (4) | Minimum main green, in ticks |
| side_green_len | input | LEN_W (4) | Side green, in ticks |
| car_sense_async | input | 1 | Side-road car sensor, asynchronous, 1 means a car is present |
| main_light | output | 3 | Main road lamps {green, yellow, red}, one-hot |
| side_light | output | 3 | Side road lamps {green, yellow, red}, one-hot |
| elapsed | output | LEN_W (4) | Ticks counted in the current phase, for display |

## Verification
The hardest case to reach is a change to a green length while that phase is already running, in particular a cut to a value below the count already reached. The counter must then not run past the new limit, and the phase must end on the next edge. Random stimulus produces this by changing the lengths (including 0) at random cycles while the sensor toggles in bursts. The directed cases add the sensor latency across the synchronizer and the zero-length limit.

// File: rtl/crossing_pkg.sv
package crossing_pkg;
   typedef enum logic [1:0] {
      PH_MAIN_GO   = 2'd0,
      PH_MAIN_WARN = 2'd1,
      PH_SIDE_GO   = 2'd2,
      PH_SIDE_WARN = 2'd3
   } phase_t;

   localparam int LAMP_W = 3;
   // Lamp vector layout: {green, yellow, red}
   localparam logic [LAMP_W-1:0] LAMP_GREEN  = 3'b100;
   localparam logic [LAMP_W-1:0] LAMP_YELLOW = 3'b010;
   localparam logic [LAMP_W-1:0] LAMP_RED    = 3'b001;
endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sig_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count,
   output logic             done
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("phase_timer: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (restart)                cnt <= '0;
      else if (tick && (cnt < limit))  cnt <= cnt + 1'b1;
   end

   assign count = cnt;
   assign done  = (cnt >= limit);

   // R9: a phase change leaves the counter at zero
   p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));
   // R9: without a tick and without a restart the count holds
   p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !tick) |=> $stable(cnt));
   // R9: the counter moves by at most one step per edge
   p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && tick && (cnt < limit)) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/phase_seq.sv
module phase_seq
   import crossing_pkg::*;
#(
   parameter int LEN_W           = 4,
   parameter int MAIN_WARN_TICKS = 3,
   parameter int SIDE_WARN_TICKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              car,
   input  logic              done,
   input  logic [LEN_W-1:0]  main_len,
   input  logic [LEN_W-1:0]  side_len,
   output logic [LEN_W-1:0]  limit,
   output logic              restart,
   output logic [LAMP_W-1:0] main_light,
   output logic [LAMP_W-1:0] side_light
);
   localparam int LEN_MAX = (1 << LEN_W) - 1;
   localparam logic [LEN_W-1:0] MW = LEN_W'(MAIN_WARN_TICKS);
   localparam logic [LEN_W-1:0] SW = LEN_W'(SIDE_WARN_TICKS);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   generate
      if (MAIN_WARN_TICKS < 1 || MAIN_WARN_TICKS > LEN_MAX) begin : g_bad_mw
         $error("phase_seq: MAIN_WARN_TICKS out of counter range");
      end
      if (SIDE_WARN_TICKS < 1 || SIDE_WARN_TICKS > LEN_MAX) begin : g_bad_sw
         $error("phase_seq: SIDE_WARN_TICKS out of counter range");
      end
   endgenerate

   phase_t phase, nxt;
   logic [LEN_W-1:0] main_lim, side_lim;

   // R11: a zero length counts as one tick
   assign main_lim = (main_len == '0) ? ONE : main_len;
   assign side_lim = (side_len == '0) ? ONE : side_len;

   always_comb begin
      case (phase)
         PH_MAIN_GO:   limit = main_lim;
         PH_MAIN_WARN: limit = MW;
         PH_SIDE_GO:   limit = side_lim;
         default:      limit = SW;
      endcase
   end

   always_comb begin
      nxt = phase;
      case (phase)
         PH_MAIN_GO:   if (done && car) nxt = PH_MAIN_WARN;
         PH_MAIN_WARN: if (done)        nxt = PH_SIDE_GO;
         PH_SIDE_GO:   if (done)        nxt = PH_SIDE_WARN;
         default:      if (done)        nxt = PH_MAIN_GO;
      endcase
   end

   assign restart = (nxt != phase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_MAIN_GO;
      else        phase <= nxt;
   end

   always_comb begin
      case (phase)
         PH_MAIN_GO:   begin main_light = LAMP_GREEN;  side_light = LAMP_RED;    end
         PH_MAIN_WARN: begin main_light = LAMP_YELLOW; side_light = LAMP_RED;    end
         PH_SIDE_GO:   begin main_light = LAMP_RED;    side_light = LAMP_GREEN;  end
         default:      begin main_light = LAMP_RED;    side_light = LAMP_YELLOW; end
      endcase
   end

   // R2: each lamp vector is one-hot
   p_lamps_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(main_light) == 1) && ($countones(side_light) == 1));
   // R3: never both roads released
   p_one_road_red_r3: assert property (@(posedge clk) disable iff (!rst_n)
      main_light[0] || side_light[0]);
   // R5: main green only ends with a synchronized car present
   p_leave_green_car_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(main_light[2]) |-> $past(car));
   // R6: main yellow is followed directly by side green
   p_yellow_to_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(main_light[1]) |-> side_light[2]);
   // R8: side yellow is followed directly by main green
   p_side_to_main_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(side_light[1]) |-> main_light[2]);
endmodule

// File: rtl/crossing_signal_ctrl.sv
module crossing_signal_ctrl
   import crossing_pkg::*;
#(
   parameter int LEN_W           = 4,
   parameter int MAIN_WARN_TICKS = 3,
   parameter int SIDE_WARN_TICKS = 2,
   parameter int SYNC_STAGES     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [LEN_W-1:0]  main_green_len,
   input  logic [LEN_W-1:0]  side_green_len,
   input  logic              car_sense_async,
   output logic [2:0]        main_light,
   output logic [2:0]        side_light,
   output logic [LEN_W-1:0]  elapsed
);
   logic             car_sync;
   logic             done;
   logic             restart;
   logic [LEN_W-1:0] limit;
   logic [LEN_W-1:0] main_floor;

   sig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(car_sense_async), .q(car_sync)
   );

   phase_seq #(
      .LEN_W(LEN_W),
      .MAIN_WARN_TICKS(MAIN_WARN_TICKS),
      .SIDE_WARN_TICKS(SIDE_WARN_TICKS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .car(car_sync), .done(done),
      .main_len(main_green_len), .side_len(side_green_len),
      .limit(limit), .restart(restart),
      .main_light(main_light), .side_light(side_light)
   );

   phase_timer #(.CNT_W(LEN_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
      .limit(limit), .count(elapsed), .done(done)
   );

   assign main_floor = (main_green_len == '0) ? LEN_W'(1) : main_green_len;

   // R4: the main green never ends before its minimum
   p_green_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(main_light[2]) |-> ($past(elapsed) >= $past(main_floor)));
   // R9: elapsed restarts when the main road changes lamp
   p_elapsed_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (main_light != $past(main_light)) |-> (elapsed == '0));
endmodule

// File: tb/crossing_signal_ctrl_test.sv
`timescale 1ns/1ps
module crossing_signal_ctrl_test;
   localparam int MWT = 3;
   localparam int SWT = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [3:0] mlen = 4'd0;
   logic [3:0] slen = 4'd0;
   logic       car = 1'b0;
   logic [2:0] main_light, side_light;
   logic [3:0] elapsed;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   // reference state
   int r_phase = 0;
   int r_cnt = 0;
   bit r_s1 = 0, r_s2 = 0;

   always #2 clk = ~clk;

   crossing_signal_ctrl uut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .main_green_len(mlen), .side_green_len(slen),
      .car_sense_async(car),
      .main_light(main_light), .side_light(side_light), .elapsed(elapsed)
   );

   function automatic int lim_of(int ph, int ml, int sl);
      case (ph)
         0: return (ml == 0) ? 1 : ml;
         1: return MWT;
         2: return (sl == 0) ? 1 : sl;
         default: return SWT;
      endcase
   endfunction

   function automatic logic [2:0] exp_main(int ph);
      return (ph == 0) ? 3'b100 : (ph == 1) ? 3'b010 : 3'b001;
   endfunction

   function automatic logic [2:0] exp_side(int ph);
      return (ph == 2) ? 3'b100 : (ph == 3) ? 3'b010 : 3'b001;
   endfunction

   function automatic string phase_tag(int ph);
      case (ph)
         0: return "R4 R5";
         1: return "R6";
         2: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(string tag, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_cycle();
      check(phase_tag(r_phase), main_light, exp_main(r_phase));
      check(phase_tag(r_phase), side_light, exp_side(r_phase));
      check("R9 elapsed", elapsed, r_cnt);
      check("R2 onehot", ($countones(main_light) == 1) && ($countones(side_light) == 1), 1);
      check("R3 red", main_light[0] | side_light[0], 1);
   endtask

   task automatic drive(bit t, bit c, int ml, int sl);
      int lim;
      int nxt;
      bit done;
      tick = t; car = c; mlen = 4'(ml); slen = 4'(sl);
      lim = lim_of(r_phase, ml, sl);
      done = (r_cnt >= lim);
      nxt = r_phase;
      case (r_phase)
         0: if (done && r_s2) nxt = 1;
         1: if (done) nxt = 2;
         2: if (done) nxt = 3;
         default: if (done) nxt = 0;
      endcase
      if (nxt != r_phase) r_cnt = 0;
      else if (t && r_cnt < lim) r_cnt++;
      r_phase = nxt;
      r_s2 = r_s1;
      r_s1 = c;
   endtask

   task automatic wait_check();
      @(negedge clk);
      check_cycle();
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      bit cur_car;
      int cur_ml, cur_sl;
      int run;
      bit was_green;
      void'($urandom(32'd4711));

      // R1: reset state, with inputs active during reset
      tick = 1'b1; car = 1'b1; mlen = 4'd5; slen = 4'd5;
      repeat (3) begin
         @(negedge clk);
         check("R1 main", main_light, 3'b100);
         check("R1 side", side_light, 3'b001);
         check("R1 elapsed", elapsed, 0);
      end
      rst_n = 1'b1;
      drive(1, 0, 2, 1);

      // R10 and R9: wait past the minimum, then raise a car
      repeat (8) begin wait_check(); drive(1, 0, 2, 1); end
      wait_check();
      check("R9 hold at limit", elapsed, 2);
      check("R5 waits for car", main_light, 3'b100);
      drive(1, 1, 2, 1);
      wait_check();
      check("R10 stage1", main_light, 3'b100);
      drive(1, 1, 2, 1);
      wait_check();
      check("R10 stage2", main_light, 3'b100);
      drive(1, 1, 2, 1);
      wait_check();
      check("R10 stage3", main_light, 3'b010);

      // R11: zero lengths with car held and a tick every cycle
      run = 0; was_green = 0;
      for (int i = 0; i < 60; i++) begin
         drive(1, 1, 0, 0);
         wait_check();
         if (main_light == 3'b100) run++;
         else begin
            if (was_green) check("R11 main green cycles", run, 2);
            run = 0;
         end
         was_green = (main_light == 3'b100);
      end

      // random traffic with length changes mid-phase
      cur_car = 0; cur_ml = 4; cur_sl = 3;
      for (int i = 0; i < 30000; i++) begin
         if ($urandom % 20 == 0) cur_car = ~cur_car;
         if ($urandom % 300 == 0) cur_ml = $urandom % 16;
         if ($urandom % 300 == 0) cur_sl = $urandom % 16;
         drive(($urandom % 3) != 0, cur_car, cur_ml, cur_sl);
         wait_check();
      end

      // R1: asynchronous reset in the middle of operation
      #1 rst_n = 1'b0;
      #0.5;
      check("R1 async main", main_light, 3'b100);
      check("R1 async side", side_light, 3'b001);
      check("R1 async elapsed", elapsed, 0);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule